// File: doc/BRIEF.md
# Ramp-Compare Reference Stepping Controller

This controller digitises the level of an analog node in a memory sense path. It drives a reference code into an external reference generator and steps that code from its lowest level (zero volts) up to full scale (the supply). It watches an external comparator that says whether the reference is now above the sensed node. Each step fills one more bit of a shift register with a one, starting at the least significant end. Each new level is held for a programmable settle time before the comparator is sampled. On the first sample that shows the reference above the node, stepping freezes and a result-valid flag rises. The frozen level is also given as a binary count of ones.

A self-test select picks what the data output shows. While it is high, the output carries the frozen reference code. While it is low, the normal read data passes through untouched, so ordinary reads keep working whatever the controller is doing. A single start pulse launches one measurement. If full scale is reached without a trip, the flag still rises and an out-of-range bit is also set.

Top module: `ramp_ref_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the reference code is all zeros, the valid and out-of-range flags are low, the level count is 0, and the data output is zero while self-test is selected.
- R2: A start pulse in idle or done clears the valid and out-of-range flags and sets the reference code to all zeros on the next edge. Each later change of the code shifts one more 1 in at bit 0 (0x00, 0x01, 0x03 … 0xFF).
- R3: With settle setting S, each reference level stays on the output for exactly S+3 clock cycles before the next level appears. The comparator passes through a two-flop synchroniser before it is sampled.
- R4: The comparator input is high when the reference is above the sensed node. When a sample sees it high, the code freezes at the sampled level (the smallest level above the node, possibly all zeros), the valid flag rises, and the out-of-range bit stays low.
- R5: If the all-ones level is sampled with the comparator low, the valid flag and the out-of-range bit both rise, and the code stays all ones.
- R6: A trip that is sampled at the all-ones level counts as a normal capture: valid rises and out-of-range stays low.
- R7: The level output is the binary count of ones in the reference code (0 to 8).
- R8: While self-test is selected, the data output equals the reference code. While it is not selected, the data output equals the normal read data in the same cycle.
- R9: A start pulse that arrives while a measurement is stepping or settling is ignored, and the code is not cleared.
- R10: Once valid is high, the code and both flags hold whatever the comparator does, until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that launches a measurement |
| test_en_i | input | 1 | Self-test select for the data output |
| settle_i | input | 4 | Extra settle cycles per reference level |
| cmp_i | input | 1 | Asynchronous comparator result, high when the reference is above the node |
| rd_data_i | input | 8 | Normal read result from the sense path |
| ref_code_o | output | 8 | Thermometer code to the reference generator |
| data_o | output | 8 | Frozen code in self-test, otherwise the read data |
| level_o | output | 4 | Binary count of ones in the reference code |
| valid_o | output | 1 | Measurement finished, result held |
| over_o | output | 1 | Full scale reached without a trip |

## Verification
Two decisions can fall on one sample: the comparator trip and the full-scale limit, which the all-ones level triggers. The bench provokes this by placing the modelled node one level below full scale, so the comparator first goes high exactly at the all-ones level. It judges the result as a normal capture, with valid high, out-of-range low and level 8. A second collision, a start pulse that lands mid-ramp, is judged by checking that the code is not cleared and that the original measurement finishes with its expected level.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STEP   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_DONE   = 2'd3
    } step_state_e;
endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ramp_popcount.sv
module ramp_popcount #(
    parameter int W     = 8,
    parameter int OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     therm_i,
    output logic [OUT_W-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + OUT_W'(therm_i[i]);
        end
    end
endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
    import ramp_pkg::*;
#(
    parameter int W     = 8,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             trip_i,
    input  logic [SET_W-1:0] settle_i,
    output logic [W-1:0]     code_o,
    output logic             valid_o,
    output logic             over_o
);
    localparam int CNT_W = SET_W + 1;

    typedef struct packed {
        step_state_e      st;
        logic [W-1:0]     code;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             over;
    } regs_t;

    regs_t r_d, r_q;
    logic [CNT_W-1:0] reload;
    logic [W-1:0]     code_q;

    assign reload = CNT_W'(settle_i) + CNT_W'(1);
    assign code_q = r_q.code;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.st    = ST_SETTLE;
                    r_d.code  = '0;
                    r_d.cnt   = reload;
                    r_d.valid = 1'b0;
                    r_d.over  = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == '0) r_d.st  = ST_STEP;
                else               r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            ST_STEP: begin
                if (trip_i) begin
                    r_d.st    = ST_DONE;
                    r_d.valid = 1'b1;
                end else if (&r_q.code) begin
                    r_d.st    = ST_DONE;
                    r_d.valid = 1'b1;
                    r_d.over  = 1'b1;
                end else begin
                    r_d.code = {r_q.code[W-2:0], 1'b1};
                    r_d.cnt  = reload;
                    r_d.st   = ST_SETTLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_IDLE;
            r_q.code  <= '0;
            r_q.cnt   <= '0;
            r_q.valid <= 1'b0;
            r_q.over  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o  = r_q.code;
    assign valid_o = r_q.valid;
    assign over_o  = r_q.over;

    // R2: the code is always a fill of ones from bit 0
    a_r2_thermo: assert property (@(posedge clk) disable iff (rst)
        ((code_q + W'(1)) & code_q) == '0);

    // R2: every nonzero change adds exactly one more one at the bottom
    a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
        (!$stable(code_q) && code_q != '0) |-> code_q == {$past(code_q[W-2:0]), 1'b1});

    // R10: a held result does not move until start
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_DONE && !start_i) |=> ($stable(code_q) && r_q.valid && $stable(r_q.over)));

    // R5: out-of-range only with full scale and valid
    a_r5_over_full: assert property (@(posedge clk) disable iff (rst)
        r_q.over |-> (&code_q && r_q.valid));

    // R9: start during a run does not clear the code
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        ((r_q.st == ST_SETTLE || r_q.st == ST_STEP) && code_q != '0) |=> code_q != '0);
endmodule

// File: rtl/ramp_ref_ctrl.sv
module ramp_ref_ctrl #(
    parameter int W        = 8,
    parameter int SET_W    = 4,
    parameter int SYNC     = 2,
    localparam int LVL_W   = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             test_en_i,
    input  logic [SET_W-1:0] settle_i,
    input  logic             cmp_i,
    input  logic [W-1:0]     rd_data_i,
    output logic [W-1:0]     ref_code_o,
    output logic [W-1:0]     data_o,
    output logic [LVL_W-1:0] level_o,
    output logic             valid_o,
    output logic             over_o
);
    logic trip_s;

    ramp_sync #(.STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_i),
        .q_o (trip_s)
    );

    ramp_stepper #(.W(W), .SET_W(SET_W)) u_step (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .trip_i   (trip_s),
        .settle_i (settle_i),
        .code_o   (ref_code_o),
        .valid_o  (valid_o),
        .over_o   (over_o)
    );

    ramp_popcount #(.W(W), .OUT_W(LVL_W)) u_cnt (
        .therm_i (ref_code_o),
        .count_o (level_o)
    );

    always_comb begin
        data_o = test_en_i ? ref_code_o : rd_data_i;
    end

    // R7: the level count agrees with the code driven to the reference
    a_r7_level: assert property (@(posedge clk) disable iff (rst)
        32'(level_o) == $countones(ref_code_o));
endmodule

// File: tb/ramp_ref_ctrl_tb_top.sv
module ramp_ref_ctrl_tb_top;
    localparam int W = 8, SET_W = 4, LVL_W = 4;

    logic             clk = 1'b0, rst = 1'b1, start = 1'b0, test_en = 1'b1;
    logic [SET_W-1:0] settle = '0;
    logic [W-1:0]     rd_data = '0;
    logic             cmp;
    logic [W-1:0]     ref_code, data;
    logic [LVL_W-1:0] level;
    logic             valid, over;

    int th = 100;
    int n_cmp = 0, n_bad = 0;
    longint cyc = 0;

    typedef struct { int lvl; bit ovf; } exp_t;
    exp_t exp_q[$];
    exp_t cur;
    logic valid_prev = 1'b0;

    always #5 clk = ~clk;

    function automatic int ones(logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [W-1:0] therm(int k);
        logic [W-1:0] v = '0;
        for (int i = 0; i < k; i++) v[i] = 1'b1;
        return v;
    endfunction

    assign cmp = (ones(ref_code) > th);

    ramp_ref_ctrl dut_i (
        .clk(clk), .rst(rst), .start_i(start), .test_en_i(test_en),
        .settle_i(settle), .cmp_i(cmp), .rd_data_i(rd_data),
        .ref_code_o(ref_code), .data_o(data), .level_o(level),
        .valid_o(valid), .over_o(over)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pop one expected item per rising valid
    always @(negedge clk) begin
        if (rst) valid_prev = 1'b0;
        else begin
            if (valid && !valid_prev) begin
                if (exp_q.size() == 0) check("R4", "unexpected capture", 1, 0);
                else begin
                    cur = exp_q.pop_front();
                    check("R7", "level count", level, cur.lvl);
                    check("R4", "frozen code", ref_code, therm(cur.lvl));
                    check(cur.ovf ? "R5" : "R6", "out-of-range bit", over, cur.ovf);
                end
            end
            valid_prev = valid;
        end
    end

    // driver: one measurement against a node placed between levels t and t+1
    task automatic measure(int t, int s, bit mid_start);
        exp_t e;
        logic [W-1:0] prev;
        int n = 0, last = -1, incs = 0, bad_iv = 0, bad_seq = 0;
        e.lvl = (t < 0) ? 0 : ((t >= W) ? W : t + 1);
        e.ovf = (t >= W);
        exp_q.push_back(e);
        th = t;
        settle = SET_W'(s);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R2", "valid cleared by start", valid, 0);
        check("R2", "code cleared by start", ref_code, 0);
        prev = ref_code;
        while (!valid && n < 2000) begin
            @(negedge clk);
            n++;
            if (ref_code != prev) begin
                if (ref_code != {prev[W-2:0], 1'b1}) bad_seq++;
                if (last >= 0 && (n - last) != s + 3) bad_iv++;
                last = n;
                incs++;
                prev = ref_code;
                if (mid_start && incs == 2) begin
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    n++;
                    check("R9", "code kept after mid-run start", (ref_code != '0), 1);
                end
            end
        end
        check("R2", "code sequence errors", bad_seq, 0);
        if (incs >= 2) check("R3", "level hold errors", bad_iv, 0);
        check("R4", "capture reached", valid, 1);
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset code", ref_code, 0);
        check("R1", "reset valid", valid, 0);
        check("R1", "reset over", over, 0);
        check("R1", "reset level", level, 0);
        check("R1", "reset data", data, 0);

        measure(3, 2, 1'b0);
        check("R8", "self-test data", data, 8'h0F);
        test_en = 1'b0;
        rd_data = 8'hA5;
        #1 check("R8", "read pass-through", data, 8'hA5);
        rd_data = 8'h3C;
        #1 check("R8", "read pass-through", data, 8'h3C);
        test_en = 1'b1;
        #1 check("R8", "self-test data again", data, 8'h0F);

        th = -1;
        repeat (5) @(negedge clk);
        check("R10", "code held, comparator high", ref_code, 8'h0F);
        check("R10", "valid held", valid, 1);
        th = 100;
        repeat (5) @(negedge clk);
        check("R10", "code held, comparator low", ref_code, 8'h0F);
        check("R10", "over held", over, 0);

        measure(-1, 1, 1'b0);
        measure(7, 1, 1'b0);
        measure(8, 0, 1'b0);
        measure(6, 2, 1'b1);
        measure(2, 15, 1'b0);
        check("R4", "no leftover expectations", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule